// File: doc/BRIEF.md
# Machine Cycle Clock Divider Controller

This block turns the system clock into a machine-cycle enable strobe. The strobe is a one-clock pulse that repeats every 4, 64 or 1024 clocks. A two-bit ratio field in an 8-bit power control register selects the spacing. Software writes the register through a simple write port and can always read it back.

The controller rejects any ratio change that does not pass through the divide-by-4 setting. It also rejects the unused code. When the switchback enable bit is set, two events force the ratio back to divide-by-4 without software help. The first is an enabled interrupt being recognised. The second is the first instruction boundary after a falling edge on the serial receive line.

The CPU core, the interrupt controller and the UART are not part of this block. Their events arrive as single-cycle pulses, and the receive line arrives as a raw level. Whenever the ratio changes, the cycle counter starts again from zero, so no period is split between two ratios.

Top module: `mcycle_divider`

## Requirements
- R1: After reset the readback is 8'h40: ratio code 01 (divide-by-4) and every other bit clear. The first strobe comes in the fourth clock after reset is released.
- R2: The ratio field is bits 7:6. Code 01 gives a strobe every 4 clocks, 10 every 64 clocks and 11 every 1024 clocks. Each strobe is high for exactly one clock.
- R3: A write whose ratio field holds the reserved code 00 leaves the ratio unchanged. The other stored bits still take the written value.
- R4: From code 01, a write of 10 or 11 is accepted. From 10 or 11, only 01 or the same code is accepted, so a write going directly between 10 and 11 leaves the ratio unchanged.
- R5: When the ratio changes, the cycle counter restarts. The first strobe at the new ratio comes N clocks after the clock edge that made the change.
- R6: When bit 5 (switchback enable) is set, an interrupt-recognised pulse makes the readback show ratio 01 in the cycle after the pulse.
- R7: When bit 5 is set, a falling edge on the receive line passes through a two-stage synchroniser and arms a pending flag. The first instruction-boundary pulse that comes after the flag is armed forces ratio 01. Boundary pulses that come before the flag is armed have no effect.
- R8: When bit 5 is clear, interrupt pulses, receive-line edges and instruction-boundary pulses leave the ratio unchanged.
- R9: Bit 2 (pin strobe disable) and bit 0 (on-chip data RAM enable) are plain storage. Bits 4, 3 and 1 always read 0.
- R10: When a switchback and a register write happen in the same cycle, the ratio becomes 01. The write still updates every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register readback |
| intRecog | input | 1 | Pulse: enabled interrupt recognised, vectoring begins |
| serRx | input | 1 | Serial receive line, idle high |
| insnStart | input | 1 | Pulse: an instruction begins |
| mcStrobe | output | 1 | Machine-cycle enable strobe |

## Verification
A wrong ratio state shows at the readback in the very next cycle. It also bends the strobe spacing within one period at the new ratio, so a fault can take up to 1024 clocks to appear on the strobe. A counter that fails to restart shows up as a short or long first period right after a change. A pending flag that arms at the wrong time moves the serial switchback by one or more instruction-boundary pulses, so the bench fires boundary pulses both before and after the flag is armed. A reference model is compared with both outputs on every cycle, so any of these faults is caught in the cycle it first shows.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    RATIO_RSVD = 2'b00,
    RATIO_FAST = 2'b01,
    RATIO_MID  = 2'b10,
    RATIO_SLOW = 2'b11
  } ratio_e;

  // Field positions within the control register
  localparam int BitCdHi   = 7;
  localparam int BitCdLo   = 6;
  localparam int BitSwb    = 5;
  localparam int BitPinOff = 2;
  localparam int BitRamEn  = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic   restart;
    ratio_e ratio;
  } ctlStrobes_t;

  // A move is legal when it avoids the reserved code and touches the fast ratio
  function automatic logic legalMove(ratio_e cur, ratio_e req);
    return (req != RATIO_RSVD) &&
           ((cur == RATIO_FAST) || (req == RATIO_FAST) || (req == cur));
  endfunction

endpackage

// File: rtl/mcd_rx_fall.sv
module mcd_rx_fall #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic fall
);

  logic [Stages-1:0] syncQ;
  logic              lastQ;

  generate
    if (Stages == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[Stages-2:0], rxIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b1;
    else       lastQ <= syncQ[Stages-1];
  end

  assign fall = lastQ & ~syncQ[Stages-1];

endmodule

// File: rtl/mcd_control.sv
module mcd_control
  import mcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regWdata,
  input  logic        intRecog,
  input  logic        rxFall,
  input  logic        insnStart,
  output logic [7:0]  regRdata,
  output ctlStrobes_t ctl
);

  ratio_e ratioQ, ratioD, reqRatio;
  logic   swbQ, pinOffQ, ramEnQ, pendQ;
  logic   swTrig;

  always_comb begin
    reqRatio = ratio_e'(regWdata[BitCdHi:BitCdLo]);
    swTrig   = swbQ & (intRecog | (pendQ & insnStart));
    ratioD   = ratioQ;
    if (swTrig)                                ratioD = RATIO_FAST;
    else if (regWr && legalMove(ratioQ, reqRatio)) ratioD = reqRatio;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioQ  <= RATIO_FAST;
      swbQ    <= 1'b0;
      pinOffQ <= 1'b0;
      ramEnQ  <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      ratioQ <= ratioD;
      pendQ  <= swbQ & ((pendQ & ~insnStart) | rxFall);
      if (regWr) begin
        swbQ    <= regWdata[BitSwb];
        pinOffQ <= regWdata[BitPinOff];
        ramEnQ  <= regWdata[BitRamEn];
      end
    end
  end

  always_comb begin
    regRdata                  = '0;
    regRdata[BitCdHi:BitCdLo] = ratioQ;
    regRdata[BitSwb]          = swbQ;
    regRdata[BitPinOff]       = pinOffQ;
    regRdata[BitRamEn]        = ramEnQ;
  end

  assign ctl.restart = (ratioD != ratioQ);
  assign ctl.ratio   = ratioQ;

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
  import mcd_pkg::*;
#(
  parameter int DivFast = 4,
  parameter int DivMid  = 64,
  parameter int DivSlow = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output logic        mcStrobe
);

  localparam int CntW = $clog2(DivSlow);

  logic [CntW-1:0] cntQ, lastIdx;

  always_comb begin
    unique case (ctl.ratio)
      RATIO_MID:  lastIdx = CntW'(DivMid - 1);
      RATIO_SLOW: lastIdx = CntW'(DivSlow - 1);
      default:    lastIdx = CntW'(DivFast - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            cntQ <= '0;
    else if (ctl.restart || cntQ == lastIdx) cntQ <= '0;
    else                                  cntQ <= cntQ + 1'b1;
  end

  assign mcStrobe = (cntQ == lastIdx);

endmodule

// File: rtl/mcycle_divider.sv
module mcycle_divider
  import mcd_pkg::*;
#(
  parameter int DivFast    = 4,
  parameter int DivMid     = 64,
  parameter int DivSlow    = 1024,
  parameter int SyncStages = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       intRecog,
  input  logic       serRx,
  input  logic       insnStart,
  output logic       mcStrobe
);

  ctlStrobes_t ctl;
  logic        rxFall;

  mcd_rx_fall #(.Stages(SyncStages)) u_rx (
    .clk(clk), .rstN(rstN), .rxIn(serRx), .fall(rxFall)
  );

  mcd_control u_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWdata(regWdata),
    .intRecog(intRecog), .rxFall(rxFall), .insnStart(insnStart),
    .regRdata(regRdata), .ctl(ctl)
  );

  mcd_datapath #(.DivFast(DivFast), .DivMid(DivMid), .DivSlow(DivSlow)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mcStrobe(mcStrobe)
  );

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [7:0] regRdata,
  input logic       intRecog,
  input logic       mcStrobe
);

  assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[7:6] != 2'b00);

  assert_via_fast_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[7:6] != $past(regRdata[7:6])) |->
      (regRdata[7:6] == 2'b01 || $past(regRdata[7:6]) == 2'b01));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    mcStrobe |=> !mcStrobe);

  assert_int_switchback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intRecog && regRdata[5]) |=> (regRdata[7:6] == 2'b01));

  assert_no_auto_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdata[5] && !regWr) |=> $stable(regRdata[7:6]));

  assert_zero_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[4:3] == 2'b00) && !regRdata[1]);

endmodule

bind mcycle_divider mcd_checker u_mcd_checker (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRdata(regRdata),
  .intRecog(intRecog), .mcStrobe(mcStrobe)
);

// File: tb/test_mcycle_divider.sv
module test_mcycle_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       intRecog = 1'b0;
  logic       serRx = 1'b1;
  logic       insnStart = 1'b0;
  logic       mcStrobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mcycle_divider i_mcycle_divider (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .intRecog(intRecog), .serRx(serRx),
    .insnStart(insnStart), .mcStrobe(mcStrobe)
  );

  // Behavioural reference model
  int       mRatio;
  int       mCount;
  bit       mSwb, mPin, mRam, mPend;
  bit       rxHist[$];
  logic [7:0] expReg;

  function automatic int divOf(int r);
    if (r == 2) return 64;
    if (r == 3) return 1024;
    return 4;
  endfunction

  function automatic logic [7:0] modelReg();
    logic [7:0] v;
    v = 8'h00;
    v[7:6] = mRatio[1:0];
    v[5] = mSwb; v[2] = mPin; v[0] = mRam;
    return v;
  endfunction

  always @(posedge clk) begin
    int  next, req;
    bit  trig, fallSeen;
    if (!rstN) begin
      mRatio = 1; mCount = 0; mSwb = 0; mPin = 0; mRam = 0; mPend = 0;
      rxHist = '{1'b1, 1'b1, 1'b1};
    end else begin
      // line value seen after two sync stages, and one stage later
      fallSeen = rxHist[0] && !rxHist[1];
      trig = mSwb && (intRecog || (mPend && insnStart));
      req = int'(regWdata[7:6]);
      next = mRatio;
      if (trig) next = 1;
      else if (regWr && req != 0 && (mRatio == 1 || req == 1 || req == mRatio)) next = req;
      if (next != mRatio || mCount == divOf(mRatio) - 1) mCount = 0;
      else mCount++;
      mPend = mSwb && ((mPend && !insnStart) || fallSeen);
      if (regWr) begin
        mSwb = regWdata[5]; mPin = regWdata[2]; mRam = regWdata[0];
      end
      mRatio = next;
      void'(rxHist.pop_front());
      rxHist.push_back(serRx);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      expReg = modelReg();
      check("R2/R5 strobe", {31'b0, mcStrobe}, {31'b0, (mCount == divOf(mRatio) - 1)});
      check("R3/R4 readback", {24'b0, regRdata}, {24'b0, expReg});
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] d, bit withInt = 0);
    @(negedge clk);
    regWr = 1'b1; regWdata = d; intRecog = withInt;
    @(negedge clk);
    regWr = 1'b0; intRecog = 1'b0;
  endtask

  task automatic pulseInsn();
    @(negedge clk); insnStart = 1'b1;
    @(negedge clk); insnStart = 1'b0;
  endtask

  task automatic countStrobes(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mcStrobe) cnt++;
    end
  endtask

  initial begin
    int cnt;
    waitCyc(3);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state and first strobe in the fourth clock
    check("R1 reset value", {24'b0, regRdata}, 32'h40);
    check("R1 no strobe yet", {31'b0, mcStrobe}, 0);
    waitCyc(3);
    check("R1 first strobe", {31'b0, mcStrobe}, 1);
    waitCyc(20);

    // R2/R5: move to 64, first strobe 64 clocks after change edge
    writeReg(8'h80);
    check("R4 fast to mid accepted", {24'b0, regRdata}, 32'h80);
    waitCyc(62);
    check("R5 no early strobe", {31'b0, mcStrobe}, 0);
    waitCyc(1);
    check("R5 first strobe at 64", {31'b0, mcStrobe}, 1);
    countStrobes(128, cnt);
    check("R2 two strobes per 128 at div 64", cnt, 2);

    // R4: direct mid to slow rejected
    writeReg(8'hC0);
    check("R4 mid to slow rejected", {24'b0, regRdata}, 32'h80);
    // R3/R9: reserved code kept out, storage bits updated
    writeReg(8'h05);
    check("R3 reserved code ignored", {24'b0, regRdata}, 32'h85);
    writeReg(8'hFF);
    check("R9 unused bits read zero", {24'b0, regRdata}, 32'hA5);

    // back to fast with switchback, then slow
    writeReg(8'h60);
    check("R4 mid to fast accepted", {24'b0, regRdata}, 32'h60);
    writeReg(8'hE0);
    check("R4 fast to slow accepted", {24'b0, regRdata}, 32'hE0);
    countStrobes(2100, cnt);
    check("R2 two strobes in 2100 at div 1024", cnt, 2);

    // R6: interrupt switchback
    @(negedge clk) intRecog = 1'b1;
    @(negedge clk) intRecog = 1'b0;
    check("R6 interrupt switchback", {24'b0, regRdata}, 32'h60);
    waitCyc(10);

    // R7: serial switchback waits for the armed flag and a boundary
    writeReg(8'hA0);
    @(negedge clk) serRx = 1'b0;
    pulseInsn();
    check("R7 early boundary ignored", {24'b0, regRdata}, 32'hA0);
    waitCyc(4);
    check("R7 no change without boundary", {24'b0, regRdata}, 32'hA0);
    pulseInsn();
    check("R7 serial switchback", {24'b0, regRdata}, 32'h60);
    @(negedge clk) serRx = 1'b1;
    waitCyc(10);

    // R8: switchback disabled
    writeReg(8'h80);
    @(negedge clk) intRecog = 1'b1;
    @(negedge clk) intRecog = 1'b0;
    check("R8 interrupt ignored", {24'b0, regRdata}, 32'h80);
    @(negedge clk) serRx = 1'b0;
    waitCyc(5);
    pulseInsn();
    pulseInsn();
    check("R8 serial ignored", {24'b0, regRdata}, 32'h80);
    @(negedge clk) serRx = 1'b1;
    waitCyc(5);

    // R10: switchback wins over a same-cycle write
    writeReg(8'hA0);
    writeReg(8'hA4, 1'b1);
    check("R10 switchback beats write", {24'b0, regRdata}, 32'h64);
    waitCyc(20);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule